// File: doc/BRIEF.md
# Pipelined Horner Polynomial Evaluator

This block evaluates a fixed-degree polynomial at a stream of sample points. It uses Horner's rule, y = (((a_n*x + a_{n-1})*x + ...)*x + a_1)*x + a_0. The computation is laid out as one row of cells that run in lock-step. Partial results move in one direction only, towards the output. Cells come in pairs. The first cell of a pair scales the running value by x, and the second cell adds one coefficient.

The leftmost pair uses a_{n-1} and the rightmost adder uses a_0. The chain is seeded with a_n. Each sample travels with its own copy of x, so a new sample may enter on every clock. The sample also carries a snapshot of the coefficient bank, taken on entry. A coefficient write therefore never changes a sample that is already in flight.

Coefficients are written one at a time through an indexed port, normally while the pipeline is idle. Arithmetic is signed two's complement. Every product and every sum is truncated to the accumulator width, and overflow wraps around.

Top module: `horner_eval`

## Requirements
- R1: For every accepted sample x, `yData` equals the Horner value over coefficients a_0..a_DEGREE, computed in ACC_W-bit signed arithmetic.
- R2: A sample accepted while `xValid` is 1 produces exactly one `yValid` pulse, 2*DEGREE clock cycles later. With the default DEGREE=4 this is 8 cycles.
- R3: Samples presented on consecutive cycles are all accepted. Their results come out on consecutive cycles, in arrival order.
- R4: In any cycle that does not correspond to an accepted sample, `yValid` is 0 and `yData` holds its previous value.
- R5: When `coefWrEn` is 1, index i in the range 0..DEGREE sets a_i to `coefWrData` at the next clock edge. An index above DEGREE changes no coefficient.
- R6: A sample accepted in the same cycle as a coefficient write uses the coefficients from before the write. A sample accepted in a later cycle uses the new value.
- R7: A coefficient write made while earlier samples are still in the chain does not change their results.
- R8: After reset, `yValid` is 0, `yData` is 0 and every coefficient is 0, so any sample evaluates to 0.
- R9: Products and sums that exceed ACC_W bits wrap modulo 2^ACC_W. They do not saturate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every cell advances on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| xValid | input | 1 | Marks `xData` as a sample to evaluate |
| xData | input | X_W | Signed sample point |
| coefWrEn | input | 1 | Coefficient write strobe |
| coefWrIdx | input | $clog2(DEGREE+1) | Index of the coefficient to write (i selects a_i) |
| coefWrData | input | C_W | Signed coefficient value |
| yValid | output | 1 | Marks `yData` as a finished result |
| yData | output | ACC_W | Signed polynomial value |

## Verification
A coefficient write and a sample entry can fall in the same cycle. The same holds for a write and samples still in flight. To provoke both cases, the bench issues a write in the very cycle that a sample is accepted, and issues further writes in the middle of a back-to-back stream. A bench model predicts every result from the coefficient bank as it stood on the sample's entry cycle, ahead of that cycle's write. The arrival cycle and the value of each output are compared with that prediction.

// File: rtl/horner_pkg.sv
package horner_pkg;

  // Strobes handed from the control unit to the datapath each cycle.
  typedef struct packed {
    logic entryLoad;   // a sample enters the first cell this cycle
    logic coefWrite;   // an in-range coefficient write happens this cycle
  } hornerStrobes_t;

endpackage

// File: rtl/horner_ctrl.sv
module horner_ctrl
  import horner_pkg::*;
#(
  parameter int DEGREE = 4,
  parameter int IDX_W  = $clog2(DEGREE + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 xValid,
  input  logic                 coefWrEn,
  input  logic [IDX_W-1:0]     coefWrIdx,
  output hornerStrobes_t       strobes,
  output logic [2*DEGREE-1:0]  stageEn,
  output logic                 yValid
);

  localparam int STAGES = 2 * DEGREE;
  localparam int CNT_W  = $clog2(STAGES + 1) + 1;

  logic [STAGES-1:0] vldQ;   // vldQ[k] = cell k holds a live sample

  always_comb begin
    strobes.entryLoad = xValid;
    strobes.coefWrite = coefWrEn && (int'(coefWrIdx) <= DEGREE);
  end

  // Cell k loads when its left neighbour presents a live sample.
  always_comb begin
    stageEn[0] = xValid;
    for (int k = 1; k < STAGES; k++) stageEn[k] = vldQ[k-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vldQ <= '0;
    else       vldQ <= {vldQ[STAGES-2:0], xValid};
  end

  assign yValid = vldQ[STAGES-1];

  // Occupancy counter used only by the checks below.
  logic [CNT_W-1:0] inFlight;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inFlight <= '0;
    else       inFlight <= inFlight + CNT_W'(xValid) - CNT_W'(yValid);
  end

  p_inflight_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    int'(inFlight) <= STAGES);

  p_out_needs_in_r4: assert property (@(posedge clk) disable iff (!rstN)
    yValid |-> (inFlight != '0));

  p_full_chain_r3: assert property (@(posedge clk) disable iff (!rstN)
    (int'(inFlight) == STAGES) |-> yValid);

endmodule

// File: rtl/horner_datapath.sv
module horner_datapath
  import horner_pkg::*;
#(
  parameter int DEGREE = 4,
  parameter int X_W    = 16,
  parameter int C_W    = 16,
  parameter int ACC_W  = 32,
  parameter int IDX_W  = $clog2(DEGREE + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  hornerStrobes_t          strobes,
  input  logic [2*DEGREE-1:0]     stageEn,
  input  logic signed [X_W-1:0]   xData,
  input  logic [IDX_W-1:0]        coefWrIdx,
  input  logic [C_W-1:0]          coefWrData,
  output logic signed [ACC_W-1:0] yData
);

  localparam int STAGES = 2 * DEGREE;

  typedef logic [DEGREE:0][C_W-1:0] coefBank_t;

  coefBank_t coefQ;   // live bank, element i holds a_i

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  coefQ <= '0;
    else if (strobes.coefWrite) coefQ[coefWrIdx] <= coefWrData;
  end

  // Per-cell state: running value, the sample's x, and its coefficient snapshot.
  logic signed [ACC_W-1:0] accQ  [STAGES];
  logic signed [X_W-1:0]   xQ    [STAGES];
  coefBank_t               snapQ [STAGES];

  logic signed [ACC_W-1:0] accIn  [STAGES];
  logic signed [X_W-1:0]   xIn    [STAGES];
  coefBank_t               snapIn [STAGES];
  logic signed [ACC_W-1:0] accNext[STAGES];

  // Left-hand inputs: cell 0 sees the entering sample seeded with a_n.
  always_comb begin
    accIn[0]  = ACC_W'(signed'(coefQ[DEGREE]));
    xIn[0]    = xData;
    snapIn[0] = coefQ;
    for (int k = 1; k < STAGES; k++) begin
      accIn[k]  = accQ[k-1];
      xIn[k]    = xQ[k-1];
      snapIn[k] = snapQ[k-1];
    end
  end

  // Even cells scale by x; odd cell 2j+1 adds a_(DEGREE-1-j).
  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_cell
      if ((k % 2) == 0) begin : g_mul
        always_comb accNext[k] = accIn[k] * ACC_W'(xIn[k]);
      end else begin : g_add
        localparam int CIDX = DEGREE - 1 - (k - 1) / 2;
        always_comb accNext[k] = accIn[k] + ACC_W'(signed'(snapIn[k][CIDX]));
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < STAGES; k++) begin
        accQ[k]  <= '0;
        xQ[k]    <= '0;
        snapQ[k] <= '0;
      end
    end else begin
      for (int k = 0; k < STAGES; k++) begin
        if (stageEn[k]) begin
          accQ[k]  <= accNext[k];
          xQ[k]    <= xIn[k];
          snapQ[k] <= snapIn[k];
        end
      end
    end
  end

  assign yData = accQ[STAGES-1];

  p_coef_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.coefWrite |=> (coefQ[$past(coefWrIdx)] == $past(coefWrData)));

  p_coef_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.coefWrite |=> $stable(coefQ));

  p_snapshot_old_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.entryLoad |=> (snapQ[0] == $past(coefQ)));

  p_out_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !stageEn[STAGES-1] |=> $stable(yData));

endmodule

// File: rtl/horner_eval.sv
module horner_eval
  import horner_pkg::*;
#(
  parameter int DEGREE = 4,
  parameter int X_W    = 16,
  parameter int C_W    = 16,
  parameter int ACC_W  = 32,
  parameter int IDX_W  = $clog2(DEGREE + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    xValid,
  input  logic signed [X_W-1:0]   xData,
  input  logic                    coefWrEn,
  input  logic [IDX_W-1:0]        coefWrIdx,
  input  logic [C_W-1:0]          coefWrData,
  output logic                    yValid,
  output logic signed [ACC_W-1:0] yData
);

  hornerStrobes_t      strobes;
  logic [2*DEGREE-1:0] stageEn;

  horner_ctrl #(.DEGREE(DEGREE), .IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .xValid    (xValid),
    .coefWrEn  (coefWrEn),
    .coefWrIdx (coefWrIdx),
    .strobes   (strobes),
    .stageEn   (stageEn),
    .yValid    (yValid)
  );

  horner_datapath #(
    .DEGREE(DEGREE), .X_W(X_W), .C_W(C_W), .ACC_W(ACC_W), .IDX_W(IDX_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .stageEn    (stageEn),
    .xData      (xData),
    .coefWrIdx  (coefWrIdx),
    .coefWrData (coefWrData),
    .yData      (yData)
  );

endmodule

// File: tb/tb_horner_eval.sv
module tb_horner_eval;

  localparam int CLK_PERIOD = 10;
  localparam int DEGREE = 4;
  localparam int X_W    = 16;
  localparam int C_W    = 16;
  localparam int ACC_W  = 32;
  localparam int IDX_W  = $clog2(DEGREE + 1);
  localparam int LAT    = 2 * DEGREE;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic xValid = 1'b0;
  logic signed [X_W-1:0] xData = '0;
  logic coefWrEn = 1'b0;
  logic [IDX_W-1:0] coefWrIdx = '0;
  logic [C_W-1:0] coefWrData = '0;
  logic yValid;
  logic signed [ACC_W-1:0] yData;

  horner_eval #(.DEGREE(DEGREE), .X_W(X_W), .C_W(C_W), .ACC_W(ACC_W)) dut (
    .clk(clk), .rstN(rstN), .xValid(xValid), .xData(xData),
    .coefWrEn(coefWrEn), .coefWrIdx(coefWrIdx), .coefWrData(coefWrData),
    .yValid(yValid), .yData(yData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int testsRun = 0;
  int testsFailed = 0;
  int cyc = 0;
  string curTag = "R1";

  logic signed [C_W-1:0] refCoef [DEGREE+1];
  logic signed [ACC_W-1:0] expQ [$];
  int dueQ [$];
  logic signed [ACC_W-1:0] lastY = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic signed [ACC_W-1:0] evalRef(input logic signed [X_W-1:0] x);
    logic signed [ACC_W-1:0] acc;
    acc = ACC_W'(refCoef[DEGREE]);
    for (int j = DEGREE - 1; j >= 0; j--) begin
      acc = acc * ACC_W'(x);
      acc = acc + ACC_W'(refCoef[j]);
    end
    return acc;
  endfunction

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", curTag, what, act, exp);
    end
  endtask

  // Scoreboard: timing (R2) and value (R1) of every result, silence otherwise (R4).
  always @(negedge clk) begin
    if (rstN) begin
      if (yValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R4 unexpected yValid", 1, 0);
        end else begin
          logic signed [ACC_W-1:0] e;
          int d;
          e = expQ.pop_front();
          d = dueQ.pop_front();
          check(cyc == d, "R2 result cycle", cyc, d);
          check(yData == e, "R1 result value", yData, e);
        end
        lastY = yData;
      end else begin
        if (dueQ.size() != 0 && dueQ[0] <= cyc)
          check(1'b0, "R2 missing yValid", 0, 1);
        check(yData == lastY, "R4 yData held", yData, lastY);
      end
    end
  end

  task automatic step(input bit xv, input logic signed [X_W-1:0] x,
                      input bit we, input int idx, input logic signed [C_W-1:0] d);
    @(negedge clk);
    xValid = xv; xData = x;
    coefWrEn = we; coefWrIdx = IDX_W'(idx); coefWrData = d;
    if (xv) begin
      expQ.push_back(evalRef(x));
      dueQ.push_back(cyc + LAT);
    end
    if (we && idx <= DEGREE) refCoef[idx] = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 0, '0);
  endtask

  task automatic drain();
    int guard = 0;
    idle(1);
    while (expQ.size() != 0 && guard < 4 * LAT) begin
      @(negedge clk);
      guard++;
    end
    idle(2);
    check(expQ.size() == 0, "queue drained", expQ.size(), 0);
  endtask

  task automatic loadAll(input logic signed [C_W-1:0] c [DEGREE+1]);
    for (int i = 0; i <= DEGREE; i++) step(1'b0, '0, 1'b1, i, c[i]);
    idle(1);
  endtask

  task automatic t_reset();
    curTag = "R8";
    @(negedge clk);
    check(yValid == 1'b0, "R8 yValid after reset", yValid, 0);
    check(yData == 0, "R8 yData after reset", yData, 0);
    step(1'b1, 16'sd123, 1'b0, 0, '0);
    step(1'b1, -16'sd77, 1'b0, 0, '0);
    drain();
  endtask

  task automatic t_single();
    logic signed [C_W-1:0] c [DEGREE+1];
    curTag = "R1";
    c = '{16'sd5, -16'sd3, 16'sd2, 16'sd7, -16'sd1};
    loadAll(c);
    step(1'b1, 16'sd3, 1'b0, 0, '0);
    drain();
    step(1'b1, -16'sd2, 1'b0, 0, '0);
    drain();
  endtask

  task automatic t_stream();
    curTag = "R3";
    for (int i = 0; i < 20; i++) step(1'b1, X_W'(i * 37 - 300), 1'b0, 0, '0);
    drain();
  endtask

  task automatic t_gaps();
    curTag = "R4";
    for (int i = 0; i < 16; i++) step((i % 3) != 1, X_W'(i * 11 - 40), 1'b0, 0, '0);
    idle(3);
    step(1'b1, 16'sd9, 1'b0, 0, '0);
    drain();
  endtask

  task automatic t_wrap();
    logic signed [C_W-1:0] c [DEGREE+1];
    curTag = "R9";
    c = '{16'sh7fff, -16'sh8000, 16'sh7fff, 16'sh1234, -16'sh8000};
    loadAll(c);
    step(1'b1, 16'sh7fff, 1'b0, 0, '0);
    step(1'b1, -16'sh8000, 1'b0, 0, '0);
    step(1'b1, 16'sd1000, 1'b0, 0, '0);
    drain();
  endtask

  task automatic t_collision();
    curTag = "R6";
    step(1'b1, 16'sd4, 1'b1, DEGREE, 16'sd100);
    step(1'b1, 16'sd4, 1'b1, 0, -16'sd50);
    step(1'b1, 16'sd4, 1'b0, 0, '0);
    drain();
  endtask

  task automatic t_midstream();
    curTag = "R7";
    for (int i = 0; i < 12; i++)
      step(1'b1, X_W'(i - 6), (i % 4) == 2, (i / 4) % (DEGREE + 1), C_W'(i * 13 - 20));
    drain();
  endtask

  task automatic t_bad_index();
    curTag = "R5";
    for (int i = DEGREE + 1; i < (1 << IDX_W); i++) step(1'b0, '0, 1'b1, i, 16'sh5a5a);
    step(1'b1, 16'sd6, 1'b0, 0, '0);
    step(1'b1, -16'sd6, 1'b0, 0, '0);
    drain();
  endtask

  initial begin
    for (int i = 0; i <= DEGREE; i++) refCoef[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_single();
    t_stream();
    t_gaps();
    t_wrap();
    t_collision();
    t_midstream();
    t_bad_index();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired: actual %0d expected <%0d cycles", WATCHDOG, WATCHDOG);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule